// File: doc/BRIEF.md
# Auxiliary Channel Request Engine

This block lets software assemble one request for a byte-serial auxiliary side channel, launch it, and read back the reply. Software writes the request header and any write payload into a transmit byte buffer through an indexed data register. Software then sets a start bit together with a byte count and an optional start delay. The engine streams the bytes out over a valid/ready byte interface and marks the final byte. It then collects the reply bytes into a receive buffer. Collection ends on an end-of-reply strobe, on a receive error, or when no reply arrives in time.

The request is formatted by software, not by the engine. Byte 0 holds the 4-bit request code in its upper nibble. The next two bytes are the address, high byte first. When the payload is nonempty, a length-minus-one byte comes next. Write payload bytes follow that. The transmit count is therefore 3, plus 1 for a nonempty payload, plus the payload size for writes. In the reply, buffer entry 0 carries the reply code in its upper nibble, and the remaining entries are read data. Completion raises a done flag and a maskable interrupt. Both stay set until software acknowledges them.

Top module: `aux_req_engine`

## Requirements
- R1: After reset the status word and the control readback are 0, and `irq_o` and `tx_valid_o` are low.
- R2: The control register (offset 0x00) keeps bits 0, 8, 22:20 and 29 and reads 0 elsewhere. A start request is ignored while bit 0 (enable) is clear.
- R3: A write to the data register (offset 0x18) with bit 0 clear stores byte 15:8 in the transmit buffer and then advances the pointer. With bit 31 set, the pointer is first loaded from bits 20:16. Without bit 31, the current pointer is used.
- R4: Writing bit 0 of the start register (offset 0x04) sends buffer bytes 0 to N-1 in order, where N is in bits 20:16. Each byte is held until `tx_ready_i` accepts it, and `tx_last_o` is set only with byte N-1.
- R5: A start delay D in bits 7:4 of the start register makes the first byte valid after exactly D pulses of `tick_i`. With D = 0, the first byte is valid in the cycle after the start write.
- R6: Status bit 1 (pending) is set from the start until completion. While pending, start requests and data-register writes are ignored.
- R7: Reply bytes are stored at entries 0 upward, and status bits 28:24 count them. `rx_end_i` sets done. Bytes after the 17th are dropped and set status bit 8, and the count stays at 17.
- R8: If no reply byte arrives within 400 ticks after the last request byte, status bit 7 (timeout) and done are both set.
- R9: A nonzero `rx_err_i` during reply collection sets done and freezes the count. The byte that carries the error is not stored. The error bits [0..11] appear at status bits 8, 9, 10, 11, 12, 14, 17, 18, 19, 20, 22 and 23.
- R10: A data-register write with bits 0 and 31 set loads the read pointer from bits 20:16. Each read of the data register then returns the reply entry at the pointer in bits 15:8 and advances the pointer.
- R11: `irq_o` equals done AND NOT mask, where mask is bit 2 of the interrupt register (offset 0x0C). Done reads back at status bit 0 and at interrupt-register bit 0.
- R12: Writing 1 to bit 1 of the interrupt register clears done, and `irq_o` falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse each microsecond |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (advances the read pointer) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| tx_valid_o | output | 1 | Request byte valid |
| tx_data_o | output | 8 | Request byte |
| tx_last_o | output | 1 | Final request byte |
| tx_ready_i | input | 1 | Link accepts request byte |
| rx_valid_i | input | 1 | Reply byte valid |
| rx_data_i | input | 8 | Reply byte |
| rx_end_i | input | 1 | End of reply |
| rx_err_i | input | 12 | Receive error indications |
| irq_o | output | 1 | Done interrupt |

## Verification
Register writes take effect at the edge that samples the strobe. A start with zero delay therefore shows the first byte at the next falling edge, and a completion shows done and `irq_o` at the falling edge after the completing input. For timed results, the bench counts the tick pulses consumed between the start edge and the first valid byte, which must equal D. It also counts the ticks between the last accepted byte and the rise of `irq_o`, which must equal 400. Status is read only after completion or during a known waiting state, and reply entries are read one per cycle after the pointer load.

// File: rtl/aux_pkg.sv
package aux_pkg;
  localparam int ERR_W = 12;
  localparam int PTR_W = 5;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_SWC  = 8'h04;
  localparam logic [7:0] OFF_INT  = 8'h0C;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_DATA = 8'h18;

  localparam logic [31:0] CTRL_WMASK = 32'h2070_0101;

  typedef enum logic [1:0] {S_IDLE, S_DELAY, S_TX, S_WAIT} seq_st_e;

  function automatic logic [31:0] err_to_stat(logic [ERR_W-1:0] e);
    logic [31:0] s;
    s = '0;
    s[8]  = e[0];
    s[9]  = e[1];
    s[10] = e[2];
    s[11] = e[3];
    s[12] = e[4];
    s[14] = e[5];
    s[17] = e[6];
    s[18] = e[7];
    s[19] = e[8];
    s[20] = e[9];
    s[22] = e[10];
    s[23] = e[11];
    return s;
  endfunction
endpackage

// File: rtl/aux_byte_buf.sv
module aux_byte_buf #(
  parameter int DEPTH = 20,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && (int'(waddr_i) < DEPTH)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : 8'h00;
endmodule

// File: rtl/aux_seq.sv
module aux_seq
  import aux_pkg::*;
#(
  parameter int RX_DEPTH      = 17,
  parameter int TIMEOUT_TICKS = 400,
  localparam int CNT_W = $clog2(RX_DEPTH + 1),
  localparam int TMO_W = $clog2(TIMEOUT_TICKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [3:0]       delay_i,
  input  logic [PTR_W-1:0] nbytes_i,
  input  logic             tick_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic             tx_last_o,
  output logic [PTR_W-1:0] tx_idx_o,
  input  logic             rx_valid_i,
  input  logic             rx_end_i,
  input  logic [ERR_W-1:0] rx_err_i,
  output logic             rx_we_o,
  output logic [CNT_W-1:0] rx_cnt_o,
  output logic             busy_o,
  output logic             fin_o,
  output logic             tmo_o,
  output logic             ovf_o,
  output logic [ERR_W-1:0] err_o
);
  seq_st_e          st_q;
  logic [3:0]       dly_q;
  logic [PTR_W-1:0] idx_q, nb_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TMO_W-1:0] tmo_cnt_q;
  logic             tmo_q, ovf_q;
  logic [ERR_W-1:0] err_q;
  logic             room, tmo_hit;

  assign room    = cnt_q < CNT_W'(RX_DEPTH);
  assign tmo_hit = tick_i && !rx_valid_i && (cnt_q == '0) &&
                   (tmo_cnt_q == TMO_W'(TIMEOUT_TICKS - 1));

  always_comb begin
    fin_o   = 1'b0;
    rx_we_o = 1'b0;
    if (st_q == S_WAIT) begin
      if (|rx_err_i) fin_o = 1'b1;
      else begin
        rx_we_o = rx_valid_i && room;
        fin_o   = rx_end_i || tmo_hit;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      dly_q     <= '0;
      idx_q     <= '0;
      nb_q      <= '0;
      cnt_q     <= '0;
      tmo_cnt_q <= '0;
      tmo_q     <= 1'b0;
      ovf_q     <= 1'b0;
      err_q     <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (go_i) begin
          idx_q     <= '0;
          nb_q      <= nbytes_i;
          cnt_q     <= '0;
          tmo_cnt_q <= '0;
          tmo_q     <= 1'b0;
          ovf_q     <= 1'b0;
          err_q     <= '0;
          dly_q     <= delay_i;
          if (delay_i != '0)        st_q <= S_DELAY;
          else if (nbytes_i == '0)  st_q <= S_WAIT;
          else                      st_q <= S_TX;
        end
        S_DELAY: if (tick_i) begin
          if (dly_q == 4'd1) st_q <= (nb_q == '0) ? S_WAIT : S_TX;
          else               dly_q <= dly_q - 4'd1;
        end
        S_TX: if (tx_ready_i) begin
          idx_q <= idx_q + 1'b1;
          if (tx_last_o) st_q <= S_WAIT;
        end
        S_WAIT: begin
          if (|rx_err_i) begin
            err_q <= rx_err_i;
            st_q  <= S_IDLE;
          end else begin
            if (rx_valid_i) begin
              if (room) cnt_q <= cnt_q + 1'b1;
              else      ovf_q <= 1'b1;
            end
            if (rx_end_i) st_q <= S_IDLE;
            else if (tmo_hit) begin
              tmo_q <= 1'b1;
              st_q  <= S_IDLE;
            end else if (tick_i && !rx_valid_i && cnt_q == '0) begin
              tmo_cnt_q <= tmo_cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign tx_valid_o = (st_q == S_TX);
  assign tx_last_o  = (st_q == S_TX) && (idx_q == nb_q - 1'b1);
  assign tx_idx_o   = idx_q;
  assign rx_cnt_o   = cnt_q;
  assign busy_o     = (st_q != S_IDLE);
  assign tmo_o      = tmo_q;
  assign ovf_o      = ovf_q;
  assign err_o      = err_q;
endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
  import aux_pkg::*;
#(
  parameter int TX_DEPTH      = 20,
  parameter int RX_DEPTH      = 17,
  parameter int TIMEOUT_TICKS = 400,
  localparam int CNT_W = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_end_i,
  input  logic [11:0] rx_err_i,
  output logic        irq_o
);
  logic [31:0]      ctrl_q;
  logic [3:0]       delay_q;
  logic [PTR_W-1:0] nb_q, ptr_q, wptr, tx_idx;
  logic             mask_q, done_q, rd_mode_q;
  logic             busy, fin, tmo, ovf, rx_we;
  logic [ERR_W-1:0] err;
  logic [CNT_W-1:0] rx_cnt;
  logic [7:0]       rx_rdata;
  logic             sel_ctrl, sel_swc, sel_int, sel_stat, sel_data;
  logic             go, dwr, tx_we, drd, ack;
  logic [31:0]      stat;

  assign sel_ctrl = reg_addr_i == OFF_CTRL;
  assign sel_swc  = reg_addr_i == OFF_SWC;
  assign sel_int  = reg_addr_i == OFF_INT;
  assign sel_stat = reg_addr_i == OFF_STAT;
  assign sel_data = reg_addr_i == OFF_DATA;

  assign go    = reg_we_i && sel_swc && reg_wdata_i[0] && ctrl_q[0] && !busy;
  assign dwr   = reg_we_i && sel_data && !busy;
  assign tx_we = dwr && !reg_wdata_i[0];
  assign drd   = reg_re_i && sel_data && rd_mode_q && !dwr;
  assign ack   = reg_we_i && sel_int && reg_wdata_i[1];
  assign wptr  = reg_wdata_i[31] ? reg_wdata_i[20:16] : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      delay_q   <= '0;
      nb_q      <= '0;
      mask_q    <= 1'b0;
      done_q    <= 1'b0;
      ptr_q     <= '0;
      rd_mode_q <= 1'b0;
    end else begin
      if (reg_we_i && sel_ctrl) ctrl_q <= reg_wdata_i & CTRL_WMASK;
      if (reg_we_i && sel_swc) begin
        delay_q <= reg_wdata_i[7:4];
        nb_q    <= reg_wdata_i[20:16];
      end
      if (reg_we_i && sel_int) mask_q <= reg_wdata_i[2];
      // completion wins over a same-cycle acknowledge
      if (fin)      done_q <= 1'b1;
      else if (ack) done_q <= 1'b0;
      if (dwr) begin
        rd_mode_q <= reg_wdata_i[0];
        ptr_q     <= reg_wdata_i[0] ? wptr : wptr + 1'b1;
      end else if (drd) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  aux_byte_buf #(.DEPTH(TX_DEPTH), .AW(PTR_W)) u_txbuf (
    .clk_i, .rst_ni,
    .we_i(tx_we), .waddr_i(wptr), .wdata_i(reg_wdata_i[15:8]),
    .raddr_i(tx_idx), .rdata_o(tx_data_o)
  );

  aux_byte_buf #(.DEPTH(RX_DEPTH), .AW(PTR_W)) u_rxbuf (
    .clk_i, .rst_ni,
    .we_i(rx_we), .waddr_i(PTR_W'(rx_cnt)), .wdata_i(rx_data_i),
    .raddr_i(ptr_q), .rdata_o(rx_rdata)
  );

  aux_seq #(.RX_DEPTH(RX_DEPTH), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_seq (
    .clk_i, .rst_ni,
    .go_i(go), .delay_i(reg_wdata_i[7:4]), .nbytes_i(reg_wdata_i[20:16]),
    .tick_i,
    .tx_ready_i, .tx_valid_o, .tx_last_o, .tx_idx_o(tx_idx),
    .rx_valid_i, .rx_end_i, .rx_err_i,
    .rx_we_o(rx_we), .rx_cnt_o(rx_cnt),
    .busy_o(busy), .fin_o(fin), .tmo_o(tmo), .ovf_o(ovf), .err_o(err)
  );

  always_comb begin
    stat        = err_to_stat(err);
    stat[0]     = done_q;
    stat[1]     = busy;
    stat[7]     = tmo;
    stat[8]     = stat[8] | ovf;
    stat[28:24] = 5'(rx_cnt);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_ctrl) reg_rdata_o = ctrl_q;
    if (sel_swc)  reg_rdata_o = {11'd0, nb_q, 8'd0, delay_q, 4'd0};
    if (sel_int)  reg_rdata_o = {29'd0, mask_q, 1'b0, done_q};
    if (sel_stat) reg_rdata_o = stat;
    if (sel_data) reg_rdata_o = {11'd0, ptr_q, (rd_mode_q ? rx_rdata : 8'h00),
                                 7'd0, rd_mode_q};
  end

  assign irq_o = done_q && !mask_q;
endmodule

// File: rtl/aux_req_chk.sv
module aux_req_chk #(
  parameter int RX_DEPTH = 17,
  localparam int CNT_W = $clog2(RX_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_valid_i,
  input logic             tx_last_i,
  input logic             tx_ready_i,
  input logic [7:0]       tx_data_i,
  input logic             irq_i,
  input logic             done_i,
  input logic             mask_i,
  input logic             busy_i,
  input logic             ack_i,
  input logic [CNT_W-1:0] rx_cnt_i
);
  a_r4_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_i |-> tx_valid_i);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_ready_i) |=> (tx_valid_i && $stable(tx_data_i)));

  a_r11_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (done_i && !mask_i));

  a_r12_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !busy_i) |=> !irq_i);

  a_r7_cnt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_i <= CNT_W'(RX_DEPTH));

  a_r6_pending_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);
endmodule

bind aux_req_engine aux_req_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tx_valid_i(tx_valid_o), .tx_last_i(tx_last_o), .tx_ready_i(tx_ready_i),
  .tx_data_i(tx_data_o), .irq_i(irq_o), .done_i(done_q), .mask_i(mask_q),
  .busy_i(busy), .ack_i(ack), .rx_cnt_i(rx_cnt)
);

// File: tb/sim_aux_req_engine.sv
`timescale 1ns/1ps
module sim_aux_req_engine;
  logic        clk = 1'b0, rst_ni = 1'b0, tick = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tx_valid, tx_last, tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_end = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [11:0] rx_err = '0;
  logic        irq;
  int          nchk = 0, nfail = 0;
  logic [1:0]  tdiv = '0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  aux_req_engine u0 (
    .clk_i(clk), .rst_ni, .tick_i(tick),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_end_i(rx_end),
    .rx_err_i(rx_err), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic load(logic [7:0] b[], logic [4:0] at);
    for (int i = 0; i < b.size(); i++)
      wr(8'h18, {(i == 0), 10'd0, at, b[i], 8'd0});
  endtask

  // returns at the falling edge where the last byte is presented
  task automatic collect(string req, logic [7:0] exp[]);
    int n = 0;
    for (int c = 0; c < 200 && n < exp.size(); c++) begin
      if (tx_valid) begin
        check(req, {24'd0, tx_data}, {24'd0, exp[n]});
        check({req, " last"}, {31'd0, tx_last}, {31'd0, n == exp.size() - 1});
        n++;
        if (n == exp.size()) break;
      end
      @(negedge clk);
    end
    check({req, " count"}, n, exp.size());
  endtask

  task automatic reply(logic [7:0] b[]);
    for (int i = 0; i < b.size(); i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = b[i]; rx_end = (i == b.size() - 1);
    end
    @(negedge clk); rx_valid = 1'b0; rx_end = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h10, d); check("R1 status", d, 0);
    rd(8'h00, d); check("R1 ctrl", d, 0);
    check("R1 irq/tx", {30'd0, irq, tx_valid}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R2 ctrl mask", d, 32'h2070_0101);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0001_0001);
    check("R2 no start when disabled", {31'd0, tx_valid}, 0);
    rd(8'h10, d); check("R2 not pending", d, 0);
    wr(8'h00, 32'h1);
  endtask

  task automatic t_write_req();
    logic [31:0] d;
    logic [7:0] hdr[] = '{8'h80, 8'h12, 8'h34, 8'h01, 8'hAA, 8'h55};
    load(hdr, 5'd0);
    wr(8'h04, 32'h0006_0001);
    collect("R4 write request", hdr);
    reply('{8'h00});
    rd(8'h10, d); check("R7 reply count done", d, 32'h0100_0001);
    check("R11 irq", {31'd0, irq}, 1);
    wr(8'h0C, 32'h2);
    check("R12 irq low after ack", {31'd0, irq}, 0);
    rd(8'h0C, d); check("R12 done cleared", d, 0);
  endtask

  task automatic t_read_req();
    logic [31:0] d;
    int ticks = 0;
    logic [7:0] hdr[] = '{8'h90, 8'h00, 8'h10, 8'h03};
    load(hdr, 5'd0);
    wr(8'h04, 32'h0004_0031);
    for (int c = 0; c < 100; c++) begin
      if (tx_valid) break;
      if (tick) ticks++;
      @(negedge clk);
    end
    check("R5 start delay ticks", ticks, 3);
    collect("R4 read request", hdr);
    wr(8'h18, 32'h8000_EE00);   // ignored while pending
    wr(8'h04, 32'h0001_0001);   // ignored while pending
    rd(8'h10, d); check("R6 pending", d, 32'h0000_0002);
    reply('{8'h00, 8'h11, 8'h22, 8'h33, 8'h44});
    rd(8'h10, d); check("R7 five byte reply", d, 32'h0500_0001);
    wr(8'h18, 32'h8000_0001);
    for (int i = 0; i < 5; i++) begin
      rd(8'h18, d);
      check("R10 reply entry", (d >> 8) & 32'hFF, 32'(i * 8'h11));
    end
    wr(8'h0C, 32'h4);
    check("R11 masked irq", {31'd0, irq}, 0);
    rd(8'h0C, d); check("R11 done visible when masked", d, 32'h5);
    wr(8'h0C, 32'h2);
    rd(8'h10, d); check("R12 done cleared", d & 32'h1, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    int ticks = 0;
    wr(8'h04, 32'h0001_0001);
    collect("R6 buffer kept after busy write", '{8'h90});
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (irq) break;
      if (tick) ticks++;
    end
    check("R8 timeout ticks", ticks, 400);
    rd(8'h10, d); check("R8 timeout status", d, 32'h0000_0081);
    wr(8'h0C, 32'h2);
  endtask

  task automatic t_error();
    logic [31:0] d;
    wr(8'h04, 32'h0001_0001);
    collect("R9 request", '{8'h90});
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h77; rx_err = 12'h020;
    @(negedge clk); rx_valid = 1'b0; rx_err = '0;
    rd(8'h10, d); check("R9 error status", d, 32'h0000_4001);
    check("R9 irq", {31'd0, irq}, 1);
    wr(8'h0C, 32'h2);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    logic [7:0] b[] = new[19];
    for (int i = 0; i < 19; i++) b[i] = 8'h40 + 8'(i);
    wr(8'h04, 32'h0001_0001);
    collect("R7 request", '{8'h90});
    reply(b);
    rd(8'h10, d); check("R7 overflow status", d, 32'h1100_0101);
    wr(8'h18, 32'h8010_0001);
    rd(8'h18, d); check("R7 last kept entry", (d >> 8) & 32'hFF, 32'h50);
    wr(8'h0C, 32'h2);
  endtask

  task automatic t_index();
    wr(8'h18, 32'h8002_C300);
    wr(8'h18, 32'h0000_C400);
    wr(8'h04, 32'h0004_0001);
    collect("R3 indexed load", '{8'h90, 8'h00, 8'hC3, 8'hC4});
    reply('{8'h00});
    wr(8'h0C, 32'h2);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        t_reset();
        t_ctrl();
        t_write_req();
        t_read_req();
        t_timeout();
        t_error();
        t_overflow();
        t_index();
      end
      begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule